// File: doc/BRIEF.md
# Ready Pin Event Detector

This block watches a set of external ready/busy lines coming from NAND flash devices. It brings each line into the clock domain through a synchronizer and shows the synchronized level as a live status bit. The live status does not depend on any other setting in the block. Each line has its own polarity bit, which decides which edge means the device has just become ready. When that edge appears, a sticky event flag for the line is set. Software clears a flag by writing one to its bit.

A per-line interrupt enable masks the flags onto a single interrupt output. The output is high while any enabled flag is set. Flags keep latching while their enable is off, so software can turn an enable on later and still see an earlier event.

Register access uses a plain, single-cycle write strobe with a select and data word. Reads are a combinational mux driven by a separate read select. There is no data stream at this block's edge, so it has no valid/ready interface and no back-pressure rules.

Top module: `ready_evt_irq`

## Requirements
- R1: The block serves NPIN (default 4) independent lines. Select 0 holds one polarity bit per line in bits NPIN-1:0. A polarity bit of 0 means the line is active low (busy when low); 1 means active high. All polarity bits reset to 0.
- R2: Select 3 reads the synchronized level of each line in bits NPIN-1:0. This value reflects the pin level sampled two rising clock edges earlier.
- R3: For a line with polarity 0, a low-to-high change of its synchronized level sets that line's flag at the next rising edge. A high-to-low change does not set it.
- R4: For a line with polarity 1, a high-to-low change of its synchronized level sets that line's flag at the next rising edge. A low-to-high change does not set it.
- R5: Flags are read at select 1, bits NPIN-1:0, and stay set until cleared. Writing select 1 with a 1 in a bit clears that flag. Writing a 0 in a bit leaves that flag unchanged.
- R6: If a flag's event and a clearing write to the same bit fall on the same edge, the flag ends up set.
- R7: The interrupt enables sit in bits 11:8 of select 2, with bit 8 belonging to line 0. All other bits of every read select return 0.
- R8: The irq output is high exactly when some line has both its flag and its enable set. Flags latch even while their enable is 0.
- R9: After reset, all flags and enables are 0. No flag can be set during the first three rising edges after reset, whatever the pin levels are.
- R10: The live status follows the pins whatever the flag, enable and polarity settings are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_pin_i | input | NPIN | Raw ready/busy lines from the devices |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_sel_i | input | 2 | Register select for the write |
| wr_data_i | input | DATA_W | Write data |
| rd_sel_i | input | 2 | Register select for the read |
| rd_data_o | output | DATA_W | Read data for rd_sel_i |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that the write strobe, select and data are synchronous to clk. They also assume that a pin level seen by the synchronizer stays put long enough to be sampled, so a flag rising can always be traced to a change in the synchronized level one cycle earlier. The stimulus drives every input on the falling clock edge and holds each pin change for at least one full cycle. It also asserts reset mid-run with all pins high, to exercise the start-up suppression.

// File: rtl/ready_evt_pkg.sv
package ready_evt_pkg;
  typedef enum logic [1:0] {
    SEL_POL  = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_IEN  = 2'd2,
    SEL_LIVE = 2'd3
  } reg_sel_e;

  // bit position of the interrupt enable field inside its register
  localparam int IEN_LSB = 8;
endpackage

// File: rtl/ready_sync.sv
module ready_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ready_edge_det.sv
module ready_edge_det #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  output logic [W-1:0] evt
);
  // edges until both the synchronized level and its previous copy are valid
  localparam int WARM = STAGES + 1;
  localparam int CW   = $clog2(WARM + 1);

  logic [CW-1:0] warm_cnt;
  logic [W-1:0]  prev_lvl;
  logic          armed;

  assign armed = (warm_cnt == CW'(WARM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_cnt <= '0;
      prev_lvl <= '0;
    end else begin
      prev_lvl <= lvl;
      if (!armed) warm_cnt <= warm_cnt + 1'b1;
    end
  end

  // a change whose new level differs from the polarity bit is the ready edge
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign evt[i] = armed && (lvl[i] != prev_lvl[i]) && (lvl[i] != pol[i]);
  end
endmodule

// File: rtl/ready_flag_bank.sv
module ready_flag_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end
endmodule

// File: rtl/ready_evt_irq.sv
module ready_evt_irq
  import ready_evt_pkg::*;
#(
  parameter int NPIN        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   wait_pin_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic [NPIN-1:0] live_lvl;
  logic [NPIN-1:0] pol_q;
  logic [NPIN-1:0] ien_q;
  logic [NPIN-1:0] flag_q;
  logic [NPIN-1:0] evt;
  logic [NPIN-1:0] clr_mask;

  ready_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(wait_pin_i), .q(live_lvl)
  );

  ready_edge_det #(.W(NPIN), .STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(live_lvl), .pol(pol_q), .evt(evt)
  );

  assign clr_mask = (wr_en_i && reg_sel_e'(wr_sel_i) == SEL_FLAG)
                    ? wr_data_i[NPIN-1:0] : '0;

  ready_flag_bank #(.W(NPIN)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(evt), .clr(clr_mask), .flags(flag_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
      ien_q <= '0;
    end else if (wr_en_i) begin
      if (reg_sel_e'(wr_sel_i) == SEL_POL) pol_q <= wr_data_i[NPIN-1:0];
      if (reg_sel_e'(wr_sel_i) == SEL_IEN) ien_q <= wr_data_i[IEN_LSB +: NPIN];
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (reg_sel_e'(rd_sel_i))
      SEL_POL:  rd_data_o[NPIN-1:0]       = pol_q;
      SEL_FLAG: rd_data_o[NPIN-1:0]       = flag_q;
      SEL_IEN:  rd_data_o[IEN_LSB +: NPIN] = ien_q;
      SEL_LIVE: rd_data_o[NPIN-1:0]       = live_lvl;
      default:  rd_data_o = '0;
    endcase
  end

  assign irq_o = |(flag_q & ien_q);
endmodule

// File: rtl/ready_evt_irq_chk.sv
module ready_evt_irq_chk #(
  parameter int NPIN        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [NPIN-1:0]   flags,
  input logic [NPIN-1:0]   ien,
  input logic [NPIN-1:0]   live,
  input logic              irq
);
  localparam int WARM = SYNC_STAGES + 1;
  localparam int CW   = $clog2(WARM + 2);

  logic [CW-1:0]   edges;
  logic [NPIN-1:0] clr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   edges <= '0;
    else if (edges != CW'(WARM + 1)) edges <= edges + 1'b1;
  end

  assign clr_seen = (wr_en && wr_sel == 2'd1) ? wr_data[NPIN-1:0] : '0;

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags) & ~$past(clr_seen)) & ~flags) == '0);

  // R9
  no_early_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edges <= CW'(WARM)) |-> (flags == '0));

  // R8
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien != '0));

  // R3
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edges > 2'd2) |->
      ((flags & ~$past(flags) & ~($past(live) ^ $past(live, 2))) == '0));

  // R8
  irq_from_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq);
endmodule

bind ready_evt_irq ready_evt_irq_chk #(
  .NPIN(NPIN), .SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_sel(wr_sel_i),
  .wr_data(wr_data_i), .flags(flag_q), .ien(ien_q), .live(live_lvl),
  .irq(irq_o)
);

// File: tb/test_ready_evt_irq.sv
module test_ready_evt_irq;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pins = 4'h0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [3:0] hist [$];
  logic [3:0] m_pol = '0, m_en = '0, m_flag = '0;

  always #(CLK_P/2) clk = ~clk;

  ready_evt_irq i_ready_evt_irq (
    .clk(clk), .rst_n(rst_n), .wait_pin_i(pins), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] m_live();
    return (hist.size() >= 2) ? hist[1] : 4'h0;
  endfunction

  function automatic logic [31:0] m_read(input logic [1:0] s);
    case (s)
      2'd0: return {28'h0, m_pol};
      2'd1: return {28'h0, m_flag};
      2'd2: return {20'h0, m_en, 8'h0};
      default: return {28'h0, m_live()};
    endcase
  endfunction

  function automatic string sel_req(input logic [1:0] s);
    case (s)
      2'd0: return "R1 polarity";
      2'd1: return "R3/R4/R5 flags";
      2'd2: return "R7 enables";
      default: return "R2/R10 live";
    endcase
  endfunction

  // reference model update on each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      m_pol = '0; m_en = '0; m_flag = '0;
    end else begin
      logic [3:0] ev, clr;
      ev = '0;
      if (hist.size() >= 3) ev = (hist[1] ^ hist[2]) & (hist[1] ^ m_pol);
      clr = (wr_en && wr_sel == 2'd1) ? wr_data[3:0] : 4'h0;
      m_flag = (m_flag & ~clr) | ev;
      if (wr_en && wr_sel == 2'd0) m_pol = wr_data[3:0];
      if (wr_en && wr_sel == 2'd2) m_en = wr_data[11:8];
      hist.push_front(pins);
      if (hist.size() > 4) void'(hist.pop_back());
    end
  end

  // compare on every clock, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && !done) begin
      chk(irq == |(m_flag & m_en), "R8 irq", {31'h0, irq}, {31'h0, |(m_flag & m_en)});
      chk(rd_data == m_read(rd_sel), sel_req(rd_sel), rd_data, m_read(rd_sel));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic peek(input logic [1:0] s, input logic [31:0] exp, input string req);
    rd_sel = s;
    #1;
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  initial begin
    #(CLK_P * 150000);
    nerr++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    peek(2'd0, 32'h0, "R1 polarity reset");
    peek(2'd1, 32'h0, "R9 flags reset");
    peek(2'd2, 32'h0, "R9 enables reset");
    chk(irq == 1'b0, "R9 irq reset", {31'h0, irq}, 32'h0);
    cyc(5);

    // active-low rise on lines 0 and 1, enables still off
    pins = 4'b0011; cyc(4);
    peek(2'd3, 32'h3, "R2 live after rise");
    peek(2'd1, 32'h3, "R3 flags on rise");
    chk(irq == 1'b0, "R8 latch without enable", {31'h0, irq}, 32'h0);

    wr(2'd2, 32'h0000_0100);
    peek(2'd2, 32'h100, "R7 enable field");
    chk(irq == 1'b1, "R8 enabled flag", {31'h0, irq}, 32'h1);

    wr(2'd1, 32'h0);
    peek(2'd1, 32'h3, "R5 write zero keeps");
    wr(2'd1, 32'h1);
    peek(2'd1, 32'h2, "R5 write one clears");
    chk(irq == 1'b0, "R8 after clear", {31'h0, irq}, 32'h0);

    // active-high on lines 2 and 3
    wr(2'd0, 32'hC);
    pins = 4'b1111; cyc(4);
    peek(2'd1, 32'h2, "R4 rise ignored");
    pins = 4'b0011; cyc(4);
    peek(2'd1, 32'hE, "R4 flags on fall");
    peek(2'd3, 32'h3, "R10 live with flags set");

    // event and clear on the same edge
    wr(2'd1, 32'hF);
    pins = 4'b0010; cyc(4);
    wr(2'd1, 32'hF);
    peek(2'd1, 32'h0, "R3 fall ignored");
    pins = 4'b0011; cyc(2);
    wr(2'd1, 32'h1);
    peek(2'd1, 32'h1, "R6 set wins");

    // random phase
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 3) == 0) pins = pins ^ 4'($urandom_range(0, 15));
      rd_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1'b1;
        wr_sel = 2'($urandom_range(0, 3));
        wr_data = $urandom;
      end else begin
        wr_en = 1'b0;
      end
      cyc(1);
    end
    wr_en = 1'b0;

    // reset with all pins high: no false event from start-up
    pins = 4'hF;
    rst_n = 1'b0; cyc(2);
    rst_n = 1'b1; cyc(6);
    peek(2'd1, 32'h0, "R9 no start-up event");
    peek(2'd3, 32'hF, "R10 live after reset");
    cyc(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule